// File: doc/BRIEF.md
# Multi-Mode DMA Address Generator

This block produces the sequence of word addresses for one DMA transfer. A single `start` pulse captures the transfer parameters: the addressing mode, a base address, a length (the row width in matrix mode), a row count, a line stride and inclusive ring bounds. The block then offers one address per cycle on a valid/ready handshake, marks the final address with `last`, and pulses `done` once the transfer is complete. Moving the data, arbitrating between requesters and timing the DRAM are left to the surrounding logic.

There are four addressing modes. Linear mode counts upward from the base. Matrix mode walks a rectangle one row at a time. Ring mode counts upward and folds back from the upper ring bound to the lower one. Carried-ring mode begins each transfer at the position where the previous carried-ring transfer stopped. This lets a producer and a consumer work through a circular buffer without software keeping track of the pointer.

Top module: `dma_addr_gen`

## Requirements
- R1: With `mode` = 2'b00 (linear), the transfer issues `len` addresses: `base`, `base+1`, `base+2` and so on, modulo 2^AW.
- R2: With `mode` = 2'b01 (matrix), the transfer issues `height` rows of `len` addresses each. Addresses within a row rise by one. The first address of each row equals the first address of the previous row plus `stride`, and the first row starts at `base`.
- R3: With `mode` = 2'b10 (ring), the transfer issues `len` addresses starting at `base`. Each address is the previous one plus one, except that the address after `ring_hi` is `ring_lo`.
- R4: With `mode` = 2'b11 (carried ring), the transfer steps through the ring as in R3. It starts from an internal pointer that holds the ring successor of the last address of the previous carried-ring transfer. That pointer is 0 after reset. If the pointer lies outside [`ring_lo`, `ring_hi`] when the transfer is loaded, the transfer starts at `ring_lo` instead. A zero-length transfer leaves the pointer unchanged.
- R5: `addr_valid` rises in the cycle after an accepted `start` and stays high until the final address is accepted. An address is accepted on a clock edge where both `addr_valid` and `ready` are high. While `ready` is low, `addr` and `last` hold their values.
- R6: `last` is high only together with the final address of a transfer. `done` is high for exactly one cycle, the cycle after the final address is accepted, and is never high at the same time as `addr_valid`.
- R7: A length of zero, or a row count of zero in matrix mode, raises `done` for one cycle in the cycle after `start` and issues no address.
- R8: `start` has no effect while `busy` is high, which covers both the address phase and the `done` cycle.
- R9: After reset, `addr_valid`, `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load the parameters and begin a transfer (ignored while busy) |
| mode | input | 2 | Addressing mode: 0 linear, 1 matrix, 2 ring, 3 carried ring |
| base | input | AW | First address (modes 0 to 2) |
| len | input | LW | Transfer length, or row width in matrix mode |
| height | input | LW | Row count in matrix mode |
| stride | input | AW | Distance between row starts in matrix mode |
| ring_lo | input | AW | Lowest ring address (inclusive) |
| ring_hi | input | AW | Highest ring address (inclusive) |
| ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | `addr` holds an address of the transfer |
| addr | output | AW | Current address |
| last | output | 1 | The current address is the final one of the transfer |
| done | output | 1 | One-cycle pulse when the transfer completes |
| busy | output | 1 | A transfer is in progress or completing |

## Verification
The assertions check the following on every cycle:
- the address and `last` stay stable while `ready` is low;
- linear and carried-ring steps are correct from one accepted address to the next;
- the carried-ring address stays inside the ring bounds;
- `done` follows the accepted final beat and never overlaps `addr_valid`.

The bench's scenarios are the only place where whole-transfer behaviour shows up:
- exact row and stride sequences;
- the pointer carried across separate carried-ring transfers, including the fallback to `ring_lo`;
- zero-size completion;
- the rejection of a `start` that arrives during a transfer or during the `done` cycle.

// File: rtl/dag_pkg.sv
package dag_pkg;
   typedef enum logic [1:0] {
      DAG_LINEAR     = 2'd0,
      DAG_MATRIX     = 2'd1,
      DAG_RING       = 2'd2,
      DAG_RING_CARRY = 2'd3
   } dag_mode_e;

   typedef enum logic [1:0] {
      DAG_IDLE = 2'd0,
      DAG_RUN  = 2'd1,
      DAG_FIN  = 2'd2
   } dag_state_e;
endpackage

// File: rtl/dag_ring_step.sv
// Successor of an address inside an inclusive ring window.
module dag_ring_step #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   output logic [AW-1:0] nxt
);
   always_comb begin
      if (cur == hi) nxt = lo;
      else           nxt = cur + AW'(1);
   end
endmodule

// File: rtl/dag_beat_count.sv
// Column/row beat counter; flags row end and final beat.
module dag_beat_count #(
   parameter int LW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          adv,
   input  logic [LW-1:0] cols,
   input  logic [LW-1:0] rows,
   output logic          row_end,
   output logic          final_beat
);
   logic [LW-1:0] cols_q, rows_q, col_q, row_q;

   assign row_end    = (col_q == cols_q - LW'(1));
   assign final_beat = row_end && (row_q == rows_q - LW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cols_q <= '0;
         rows_q <= '0;
         col_q  <= '0;
         row_q  <= '0;
      end else if (load) begin
         cols_q <= cols;
         rows_q <= rows;
         col_q  <= '0;
         row_q  <= '0;
      end else if (adv) begin
         if (row_end) begin
            col_q <= '0;
            row_q <= row_q + LW'(1);
         end else begin
            col_q <= col_q + LW'(1);
         end
      end
   end
endmodule

// File: rtl/dag_carry_ptr.sv
// Pointer carried between carried-ring transfers; CARRY_EN=0 removes it.
module dag_carry_ptr #(
   parameter int AW       = 16,
   parameter bit CARRY_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          save,
   input  logic [AW-1:0] save_val,
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   output logic [AW-1:0] start_ptr
);
   generate
      if (CARRY_EN) begin : g_carry
         logic [AW-1:0] ptr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    ptr_q <= '0;
            else if (save) ptr_q <= save_val;
         end
         assign start_ptr = (ptr_q >= lo && ptr_q <= hi) ? ptr_q : lo;
      end else begin : g_fixed
         logic unused_ok;
         assign unused_ok = ^{clk, rst_n, save, save_val, hi};
         assign start_ptr = lo;
      end
   endgenerate
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
   import dag_pkg::*;
#(
   parameter int AW       = 16,
   parameter int LW       = 12,
   parameter bit CARRY_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    mode,
   input  logic [AW-1:0] base,
   input  logic [LW-1:0] len,
   input  logic [LW-1:0] height,
   input  logic [AW-1:0] stride,
   input  logic [AW-1:0] ring_lo,
   input  logic [AW-1:0] ring_hi,
   input  logic          ready,
   output logic          addr_valid,
   output logic [AW-1:0] addr,
   output logic          last,
   output logic          done,
   output logic          busy
);
   generate
      if (AW < 2 || LW < 1) begin : g_bad_param
         $error("dma_addr_gen: AW must be >= 2 and LW >= 1");
      end
   endgenerate

   dag_state_e    state_q;
   dag_mode_e     mode_q;
   logic [AW-1:0] addr_q, row_base_q, stride_q, lo_q, hi_q;
   logic [AW-1:0] ring_nxt, ptr_start, start_addr, next_addr;
   logic [LW-1:0] rows_in;
   logic          load, accept, zero_size, row_end, final_beat;

   assign load      = start && (state_q == DAG_IDLE);
   assign accept    = (state_q == DAG_RUN) && ready;
   assign zero_size = (len == '0) || (dag_mode_e'(mode) == DAG_MATRIX && height == '0);
   assign rows_in   = (dag_mode_e'(mode) == DAG_MATRIX) ? height : LW'(1);
   assign start_addr = (dag_mode_e'(mode) == DAG_RING_CARRY) ? ptr_start : base;

   dag_ring_step #(.AW(AW)) u_step (
      .cur(addr_q), .lo(lo_q), .hi(hi_q), .nxt(ring_nxt)
   );

   dag_beat_count #(.LW(LW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .adv(accept),
      .cols(len), .rows(rows_in),
      .row_end(row_end), .final_beat(final_beat)
   );

   dag_carry_ptr #(.AW(AW), .CARRY_EN(CARRY_EN)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .save(accept && final_beat && mode_q == DAG_RING_CARRY),
      .save_val(ring_nxt), .lo(ring_lo), .hi(ring_hi),
      .start_ptr(ptr_start)
   );

   always_comb begin
      case (mode_q)
         DAG_MATRIX:             next_addr = row_end ? row_base_q + stride_q : addr_q + AW'(1);
         DAG_RING, DAG_RING_CARRY: next_addr = ring_nxt;
         default:                next_addr = addr_q + AW'(1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= DAG_IDLE;
         mode_q     <= DAG_LINEAR;
         addr_q     <= '0;
         row_base_q <= '0;
         stride_q   <= '0;
         lo_q       <= '0;
         hi_q       <= '0;
      end else begin
         case (state_q)
            DAG_IDLE: if (load) begin
               mode_q     <= dag_mode_e'(mode);
               addr_q     <= start_addr;
               row_base_q <= start_addr;
               stride_q   <= stride;
               lo_q       <= ring_lo;
               hi_q       <= ring_hi;
               state_q    <= zero_size ? DAG_FIN : DAG_RUN;
            end
            DAG_RUN: if (accept) begin
               addr_q <= next_addr;
               if (mode_q == DAG_MATRIX && row_end) row_base_q <= row_base_q + stride_q;
               if (final_beat) state_q <= DAG_FIN;
            end
            default: state_q <= DAG_IDLE;
         endcase
      end
   end

   assign addr_valid = (state_q == DAG_RUN);
   assign addr       = addr_q;
   assign last       = addr_valid && final_beat;
   assign done       = (state_q == DAG_FIN);
   assign busy       = (state_q != DAG_IDLE);
endmodule

// File: rtl/dag_checker.sv
module dag_checker #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          addr_valid,
   input logic          ready,
   input logic [AW-1:0] addr,
   input logic          last,
   input logic          done,
   input logic [1:0]    mode_q,
   input logic [AW-1:0] lo_q,
   input logic [AW-1:0] hi_q
);
   a_r5_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && !ready |=> addr_valid && $stable(addr) && $stable(last));

   a_r1_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && ready && !last && mode_q == 2'd0 |=> addr == $past(addr) + AW'(1));

   a_r4_carry_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && mode_q == 2'd3 |-> addr >= lo_q && addr <= hi_q);

   a_r4_carry_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && ready && !last && mode_q == 2'd3 && addr == hi_q |=> addr == lo_q);

   a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && ready && last |=> done && !addr_valid);

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !addr_valid ##1 !done);
endmodule

bind dma_addr_gen dag_checker #(.AW(AW)) u_dag_checker (
   .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .ready(ready),
   .addr(addr), .last(last), .done(done), .mode_q(mode_q),
   .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/test_dma_addr_gen.sv
module test_dma_addr_gen;
   localparam int AW = 16;
   localparam int LW = 12;

   typedef struct packed {
      logic [1:0]    mode;
      logic [AW-1:0] base;
      logic [LW-1:0] len;
      logic [LW-1:0] hgt;
      logic [AW-1:0] stride;
      logic [AW-1:0] lo;
      logic [AW-1:0] hi;
   } vec_t;

   // Vectors walked by the main loop; expected addresses come from the model in run_xfer.
   localparam vec_t VECS [8] = '{
      '{2'd0, 16'h0100, 12'd5, 12'd0, 16'h0000, 16'h0000, 16'h0000}, // R1
      '{2'd1, 16'h0200, 12'd3, 12'd3, 16'h0010, 16'h0000, 16'h0000}, // R2
      '{2'd2, 16'h0305, 12'd6, 12'd0, 16'h0000, 16'h0300, 16'h0307}, // R3 wrap
      '{2'd3, 16'h0000, 12'd4, 12'd0, 16'h0000, 16'h0040, 16'h0045}, // R4 fallback to lo
      '{2'd3, 16'h0000, 12'd5, 12'd0, 16'h0000, 16'h0040, 16'h0045}, // R4 carry + wrap
      '{2'd1, 16'h0010, 12'd1, 12'd2, 16'h0005, 16'h0000, 16'h0000}, // R2 width 1
      '{2'd0, 16'hFFFF, 12'd1, 12'd0, 16'h0000, 16'h0000, 16'h0000}, // R1 single beat
      '{2'd3, 16'h0000, 12'd2, 12'd0, 16'h0000, 16'h0041, 16'h0045}  // R4 pointer in range
   };

   logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0, ready = 1'b0;
   logic [1:0]    mode = '0;
   logic [AW-1:0] base = '0, stride = '0, ring_lo = '0, ring_hi = '0;
   logic [LW-1:0] len = '0, height = '0;
   logic          addr_valid, last, done, busy;
   logic [AW-1:0] addr;

   int checks = 0, errors = 0, tick = 0;
   logic [AW-1:0] mptr = '0;

   always #4 clk = ~clk;

   dma_addr_gen #(.AW(AW), .LW(LW)) i_dma_addr_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
      .len(len), .height(height), .stride(stride), .ring_lo(ring_lo),
      .ring_hi(ring_hi), .ready(ready), .addr_valid(addr_valid), .addr(addr),
      .last(last), .done(done), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] wrap(input logic [AW-1:0] a, input logic [AW-1:0] lo,
                                         input logic [AW-1:0] hi);
      return (a == hi) ? lo : a + AW'(1);
   endfunction

   task automatic run_xfer(input vec_t v, input bit inj);
      logic [AW-1:0] cur, rowb;
      int rows, total, beats, col, guard;
      bit r;
      rows  = (v.mode == 2'd1) ? int'(v.hgt) : 1;
      total = int'(v.len) * rows;
      if (v.mode == 2'd3) cur = (mptr >= v.lo && mptr <= v.hi) ? mptr : v.lo;
      else                cur = v.base;
      rowb = cur; beats = 0; col = 0; guard = 0;
      @(negedge clk);
      mode = v.mode; base = v.base; len = v.len; height = v.hgt;
      stride = v.stride; ring_lo = v.lo; ring_hi = v.hi; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (total == 0) begin
         chk(done && !addr_valid, "R7 zero-size done", {done, addr_valid}, 2'b10);
         @(negedge clk);
         chk(!done && !busy, "R7 done single cycle", {done, busy}, 0);
      end else begin
         while (beats < total && guard < 1000) begin
            chk(addr_valid, "R5 valid during transfer", addr_valid, 1);
            r = (tick % 3) != 2;
            tick++;
            ready = r;
            start = inj && (guard == 1);
            if (start) begin base = 16'hDEAD; mode = 2'd0; len = 12'd1; end
            if (addr_valid && r) begin
               chk(addr == cur, $sformatf("R%0d addr beat %0d", v.mode + 1, beats), addr, cur);
               chk(last == (beats == total - 1), "R6 last flag", last, beats == total - 1);
               if (beats == total - 1 && v.mode == 2'd3) mptr = wrap(cur, v.lo, v.hi);
               beats++; col++;
               if (v.mode == 2'd1 && col == int'(v.len)) begin
                  col = 0; rowb = rowb + v.stride; cur = rowb;
               end else if (v.mode >= 2'd2) cur = wrap(cur, v.lo, v.hi);
               else cur = cur + AW'(1);
            end
            guard++;
            @(negedge clk);
            start = 1'b0;
         end
         ready = 1'b0;
         chk(done && !addr_valid, "R6 done after last", {done, addr_valid}, 2'b10);
         if (inj) begin
            // R8: start during the done cycle must be ignored
            mode = 2'd0; base = 16'hBEEF; len = 12'd3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(!addr_valid && !done && !busy, "R8 start ignored while busy",
                {addr_valid, done, busy}, 0);
         end else begin
            @(negedge clk);
            chk(!done, "R6 done one cycle", done, 0);
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!addr_valid && !done && !busy, "R9 reset state", {addr_valid, done, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!addr_valid && !busy, "R9 idle after reset", {addr_valid, busy}, 0);

      for (int i = 0; i < 8; i++) run_xfer(VECS[i], 1'b0);

      // R7: zero length linear, zero height matrix
      run_xfer('{2'd0, 16'h0123, 12'd0, 12'd0, 16'h0, 16'h0, 16'h0}, 1'b0);
      run_xfer('{2'd1, 16'h0123, 12'd4, 12'd0, 16'h8, 16'h0, 16'h0}, 1'b0);
      // R4: zero-length carried ring leaves the pointer, next transfer resumes from it
      run_xfer('{2'd3, 16'h0, 12'd0, 12'd0, 16'h0, 16'h0041, 16'h0045}, 1'b0);
      run_xfer('{2'd3, 16'h0, 12'd3, 12'd0, 16'h0, 16'h0041, 16'h0045}, 1'b0);
      // R8: start during address phase and done cycle is ignored
      run_xfer('{2'd2, 16'h0502, 12'd5, 12'd0, 16'h0, 16'h0500, 16'h0503}, 1'b1);
      run_xfer('{2'd1, 16'h0700, 12'd2, 12'd2, 16'h0100, 16'h0, 16'h0}, 1'b1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule